// File: doc/BRIEF.md
# Bridge Device Power State Controller

This block holds the device power state of a PCI-to-PCI bridge function and carries out the side effects of each state change. Configuration software writes a two-bit requested state. The block accepts only the full-power state and the sleeping state (D3hot). Requests for the two intermediate states are dropped. On entry to D3hot it can stop the downstream clock outputs, and it reports the secondary bus as being in the B2 bus power state. On return to full power it re-enables the clocks and issues a one-cycle internal soft reset for the rest of the bridge.

Loss of power (D3cold) is not a state the block enters by a write. It is represented by the power-up reset input, which is the only way back from D3cold. A board-level strap decides whether the downstream clocks are gated in D3hot. The secondary bus reset output follows only the power-up reset and never the soft reset.

Top module: `pm_state_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released, until the first accepted write, `pwr_state` reads 00, every bit of `sec_clk_en` is 1, `soft_rst` is 0 and `sec_bus_b2` is 0. `sec_bus_rst` is 1 while `rst_n` is low and reads 0 from the first rising clock edge after release.
- R2: `pwr_state` uses the encoding 00 = D0, 01 = D1, 10 = D2, 11 = D3hot. It only ever reads 00 or 11.
- R3: A write (`cfg_wr_en` high at a rising edge) with `cfg_wr_state` equal to 01 or 10 is discarded in either state. The state, the clock enables and the soft reset are unchanged.
- R4: A write of 11 while in D0, with `clk_ctl_strap` high at that edge, makes `pwr_state` read 11 and all `sec_clk_en` bits read 0 after that edge.
- R5: A write of 11 while in D0, with `clk_ctl_strap` low at that edge, makes `pwr_state` read 11 while all `sec_clk_en` bits stay 1. Strap changes while in D3hot have no effect.
- R6: A write of 00 while in D3hot raises `soft_rst` for exactly the one cycle after the accepting edge. In that same cycle `pwr_state` reads 00 and all `sec_clk_en` bits read 1.
- R7: `sec_bus_rst` is never 1 while `soft_rst` is 1.
- R8: `sec_bus_b2` is 1 exactly when `pwr_state` reads 11.
- R9: A write of the state already held changes nothing and produces no `soft_rst` pulse.
- R10: With `cfg_wr_en` low, `cfg_wr_state` and `clk_ctl_strap` have no effect.
- R11: Driving `rst_n` low from D3hot, which models power removal (D3cold), returns every output to its R1 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| cfg_wr_en | input | 1 | Write strobe for the power state field |
| cfg_wr_state | input | 2 | Requested power state |
| clk_ctl_strap | input | 1 | 1 allows the secondary clocks to be gated in D3hot |
| pwr_state | output | 2 | Current power state readback |
| sec_clk_en | output | NUM_SEC_CLK | Per-output secondary clock enable; 0 holds that clock low |
| soft_rst | output | 1 | One-cycle internal reset pulse on wake |
| sec_bus_b2 | output | 1 | Secondary bus is in B2 bus power state |
| sec_bus_rst | output | 1 | Secondary bus reset, driven by power-up reset only |

## Verification
The bench targets the requests for the intermediate states. A decoder that let them through would leave the field reading 01 or 10, or would put the bridge to sleep. Repeated writes of the current state are also covered, where a careless design would fire a spurious soft reset or gate the clocks a second time. The strap is toggled at the sleep edge and again during D3hot, which shows up a design that samples the strap continuously instead of at entry. The wake sequence is checked cycle by cycle for a pulse that is too long or missing, for clocks left gated, and for the secondary bus reset being wrongly driven by the soft reset.

// File: rtl/pm_pkg.sv
package pm_pkg;

   typedef enum logic [1:0] {
      PS_D0    = 2'b00,
      PS_D1    = 2'b01,
      PS_D2    = 2'b10,
      PS_D3HOT = 2'b11
   } pm_state_e;

   typedef struct packed {
      logic go_sleep;
      logic go_wake;
   } pm_cmd_t;

endpackage

// File: rtl/pm_req_decode.sv
module pm_req_decode
   import pm_pkg::*;
(
   input  logic      wr_en,
   input  logic [1:0] wr_state,
   input  pm_state_e cur_state,
   output pm_cmd_t   cmd
);

   pm_state_e req;

   always_comb begin
      req          = pm_state_e'(wr_state);
      cmd.go_sleep = 1'b0;
      cmd.go_wake  = 1'b0;
      if (wr_en) begin
         unique case (req)
            PS_D3HOT: cmd.go_sleep = (cur_state == PS_D0);
            PS_D0:    cmd.go_wake  = (cur_state == PS_D3HOT);
            default:  ;
         endcase
      end
   end

endmodule

// File: rtl/pm_state_reg.sv
module pm_state_reg
   import pm_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  pm_cmd_t   cmd,
   output pm_state_e state_q,
   output logic      soft_rst_q,
   output logic      bus_rst_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= PS_D0;
         soft_rst_q <= 1'b0;
      end else begin
         soft_rst_q <= cmd.go_wake;
         if (cmd.go_sleep)
            state_q <= PS_D3HOT;
         else if (cmd.go_wake)
            state_q <= PS_D0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_rst_q <= 1'b1;
      else        bus_rst_q <= 1'b0;
   end

endmodule

// File: rtl/pm_clk_gate.sv
module pm_clk_gate
   import pm_pkg::*;
#(
   parameter int unsigned NUM_SEC_CLK = 5,
   parameter bit          HONOR_STRAP = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  pm_cmd_t                cmd,
   input  logic                   strap,
   output logic [NUM_SEC_CLK-1:0] clk_en
);

   logic gate_req;

   generate
      if (HONOR_STRAP) begin : g_strap
         assign gate_req = cmd.go_sleep & strap;
      end else begin : g_always
         assign gate_req = cmd.go_sleep;
      end
   endgenerate

   for (genvar i = 0; i < NUM_SEC_CLK; i++) begin : g_en
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            clk_en[i] <= 1'b1;
         else if (gate_req)
            clk_en[i] <= 1'b0;
         else if (cmd.go_wake)
            clk_en[i] <= 1'b1;
      end
   end

endmodule

// File: rtl/pm_state_ctrl.sv
module pm_state_ctrl
   import pm_pkg::*;
#(
   parameter int unsigned NUM_SEC_CLK = 5,
   parameter bit          HONOR_STRAP = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_wr_en,
   input  logic [1:0]             cfg_wr_state,
   input  logic                   clk_ctl_strap,
   output logic [1:0]             pwr_state,
   output logic [NUM_SEC_CLK-1:0] sec_clk_en,
   output logic                   soft_rst,
   output logic                   sec_bus_b2,
   output logic                   sec_bus_rst
);

   localparam int unsigned MAX_SEC_CLK = 64;

   generate
      if (NUM_SEC_CLK < 1 || NUM_SEC_CLK > MAX_SEC_CLK) begin : g_bad_cfg
         $error("pm_state_ctrl: NUM_SEC_CLK out of range");
      end
   endgenerate

   pm_cmd_t   cmd;
   pm_state_e state_q;

   pm_req_decode u_dec (
      .wr_en     (cfg_wr_en),
      .wr_state  (cfg_wr_state),
      .cur_state (state_q),
      .cmd       (cmd)
   );

   pm_state_reg u_st (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd        (cmd),
      .state_q    (state_q),
      .soft_rst_q (soft_rst),
      .bus_rst_q  (sec_bus_rst)
   );

   pm_clk_gate #(
      .NUM_SEC_CLK (NUM_SEC_CLK),
      .HONOR_STRAP (HONOR_STRAP)
   ) u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .cmd    (cmd),
      .strap  (clk_ctl_strap),
      .clk_en (sec_clk_en)
   );

   assign pwr_state  = state_q;
   assign sec_bus_b2 = (state_q == PS_D3HOT);

endmodule

// File: rtl/pm_state_ctrl_chk.sv
module pm_state_ctrl_chk #(
   parameter int unsigned NUM_SEC_CLK = 5
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   cfg_wr_en,
   input logic [1:0]             cfg_wr_state,
   input logic [1:0]             pwr_state,
   input logic [NUM_SEC_CLK-1:0] sec_clk_en,
   input logic                   soft_rst,
   input logic                   sec_bus_b2,
   input logic                   sec_bus_rst
);

   // R2
   legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 2'b00) || (pwr_state == 2'b11));

   // R3
   drop_mid_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr_en && (cfg_wr_state == 2'b01 || cfg_wr_state == 2'b10))
      |=> ($stable(pwr_state) && !soft_rst));

   // R6
   pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> !soft_rst);

   // R6
   pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(soft_rst) |-> ($past(pwr_state) == 2'b11 && $past(cfg_wr_en)
                           && $past(cfg_wr_state) == 2'b00));

   // R6
   wake_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |-> (&sec_clk_en && pwr_state == 2'b00));

   // R7
   no_bus_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |-> !sec_bus_rst);

   // R8
   b2_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sec_bus_b2) |-> ($past(cfg_wr_en) && $past(cfg_wr_state) == 2'b11));

   // R9
   same_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr_en && cfg_wr_state == pwr_state) |=> ($stable(pwr_state) && !soft_rst));

endmodule

bind pm_state_ctrl pm_state_ctrl_chk #(.NUM_SEC_CLK(NUM_SEC_CLK)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_wr_en    (cfg_wr_en),
   .cfg_wr_state (cfg_wr_state),
   .pwr_state    (pwr_state),
   .sec_clk_en   (sec_clk_en),
   .soft_rst     (soft_rst),
   .sec_bus_b2   (sec_bus_b2),
   .sec_bus_rst  (sec_bus_rst)
);

// File: tb/pm_state_ctrl_bench.sv
module pm_state_ctrl_bench;

   localparam int N = 5;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [1:0]   wr_st = 2'b00;
   logic         strap = 1'b0;
   logic [1:0]   pwr_state;
   logic [N-1:0] sec_clk_en;
   logic         soft_rst;
   logic         sec_bus_b2;
   logic         sec_bus_rst;

   int unsigned  n_cmp = 0;
   int unsigned  n_bad = 0;
   bit           done = 1'b0;

   logic [1:0]   m_ps;
   logic [N-1:0] m_clk;
   logic         m_pulse;

   always #4 clk = ~clk;

   pm_state_ctrl #(.NUM_SEC_CLK(N)) u_pm_state_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_wr_en     (wr_en),
      .cfg_wr_state  (wr_st),
      .clk_ctl_strap (strap),
      .pwr_state     (pwr_state),
      .sec_clk_en    (sec_clk_en),
      .soft_rst      (soft_rst),
      .sec_bus_b2    (sec_bus_b2),
      .sec_bus_rst   (sec_bus_rst)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [N-1:0] all_on();
      return {N{1'b1}};
   endfunction

   task automatic check_all(input string req);
      chk(req, "pwr_state", 32'(pwr_state), 32'(m_ps));
      chk(req, "sec_clk_en", 32'(sec_clk_en), 32'(m_clk));
      chk(req, "soft_rst", 32'(soft_rst), 32'(m_pulse));
      chk("R8", "sec_bus_b2", 32'(sec_bus_b2), 32'(m_ps == 2'b11));
      chk("R7", "sec_bus_rst", 32'(sec_bus_rst), 32'd0);
   endtask

   // one write cycle followed by one idle cycle; model updated per requirements
   task automatic step(input logic we, input logic [1:0] st, input logic sp,
                       input string req);
      @(negedge clk);
      wr_en = we; wr_st = st; strap = sp;
      m_pulse = 1'b0;
      if (we) begin
         if (m_ps == 2'b00 && st == 2'b11) begin
            m_ps  = 2'b11;
            m_clk = sp ? '0 : all_on();
         end else if (m_ps == 2'b11 && st == 2'b00) begin
            m_ps    = 2'b00;
            m_clk   = all_on();
            m_pulse = 1'b1;
         end
      end
      @(negedge clk);
      wr_en = 1'b0;
      check_all(req);
      m_pulse = 1'b0;
   endtask

   task automatic do_reset(input string req);
      @(negedge clk);
      rst_n = 1'b0; wr_en = 1'b0;
      #1;
      m_ps = 2'b00; m_clk = all_on(); m_pulse = 1'b0;
      chk(req, "sec_bus_rst in reset", 32'(sec_bus_rst), 32'd1);
      chk(req, "pwr_state in reset", 32'(pwr_state), 32'd0);
      chk(req, "sec_clk_en in reset", 32'(sec_clk_en), 32'(all_on()));
      chk(req, "sec_bus_b2 in reset", 32'(sec_bus_b2), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all(req);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      m_ps = 2'b00; m_clk = all_on(); m_pulse = 1'b0;
      do_reset("R1");

      // directed corners
      step(1'b1, 2'b01, 1'b1, "R3");
      step(1'b1, 2'b10, 1'b1, "R3");
      step(1'b1, 2'b00, 1'b1, "R9");
      step(1'b0, 2'b11, 1'b1, "R10");
      step(1'b1, 2'b11, 1'b1, "R4");
      step(1'b1, 2'b11, 1'b0, "R9");
      step(1'b1, 2'b01, 1'b0, "R3");
      step(1'b1, 2'b10, 1'b0, "R3");
      step(1'b0, 2'b00, 1'b0, "R10");
      step(1'b1, 2'b00, 1'b0, "R6");
      step(1'b1, 2'b11, 1'b0, "R5");
      step(1'b0, 2'b00, 1'b1, "R5");
      step(1'b1, 2'b00, 1'b1, "R6");
      step(1'b1, 2'b11, 1'b1, "R4");
      do_reset("R11");

      // constrained random
      for (int i = 0; i < 3000; i++) begin
         logic       we;
         logic [1:0] st;
         logic       sp;
         we = ($urandom_range(0, 3) != 0);
         st = 2'($urandom_range(0, 3));
         sp = 1'($urandom_range(0, 1));
         if (($urandom_range(0, 199)) == 0) do_reset("R11");
         else step(we, st, sp, "R3");
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule